// File: doc/BRIEF.md
# Four-Channel Converter Register Bank with Group Load

This block is the digital front end of a four-channel, 12-bit converter with a parallel bus. Each channel has two registers. The first is a staging register that the bus writes. The second is an output register whose value drives the converter. A host selects a channel with a 2-bit address, writes or reads over a 12-bit data port, and moves staged codes to the outputs in one of two ways. It can write the staging and output registers of one channel together while the load line is held low. Or it can fill the staging registers and then pulse the load line while the chip is deselected, which moves all four channels at the same instant.

All control inputs are sampled on the system clock. A write or a group load takes effect on the edge where its qualifying condition is seen. The bidirectional bus appears as a data input, a data output and an output enable. An active-low clear acts asynchronously, does not depend on chip select, and forces every register to a clear code. A build parameter sets that code to midscale or to zero.

Top module: `quad_dac_regbank`

## Requirements
- R1: Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k's output register appears on `dac_out[12*k+11 : 12*k]`, so channel A occupies the lowest 12 bits.
- R2: While `cs_n` is high, no staging register is written, whatever `rw_n`, `addr` and `din` are, and `dout_oe` stays low.
- R3: With `cs_n` low, `rw_n` low and `ldac_n` high, only the addressed staging register takes `din` on the clock edge. All output registers hold their values.
- R4: With `cs_n` low, `rw_n` low and `ldac_n` low, the addressed staging register and the addressed output register both take `din` on the same edge. The other channels are unchanged.
- R5: With `cs_n` high and `ldac_n` low, all four output registers copy their staging registers on the same edge.
- R6: With `cs_n` high and `ldac_n` high, every register holds its value.
- R7: With `cs_n` low, `rw_n` high and `ldac_n` high, `dout_oe` is high and `dout` shows the addressed staging register (not the output register), in the same cycle.
- R8: A read request (`cs_n` low, `rw_n` high) made while `ldac_n` is low does nothing: `dout_oe` stays low and no register changes.
- R9: `dout_oe` is low in every case other than the one in R7, and `dout` is 0 while `dout_oe` is low.
- R10: While `clr_n` is low, all eight registers are forced to the clear code without waiting for a clock edge, and they stay there whatever the bus does.
- R11: The clear code is 0x800 when `CLR_MID` is 1 (the default) and 0x000 when `CLR_MID` is 0.
- R12: After `rst_n` is asserted, all eight registers hold the clear code.
- R13: Codes are straight binary, with bit 11 the MSB. The extremes 0x000 and 0xFFF are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which every bus input is sampled |
| rst_n | input | 1 | Active-low asynchronous reset to the clear code |
| clr_n | input | 1 | Active-low asynchronous clear to the clear code, independent of chip select |
| cs_n | input | 1 | Active-low chip select |
| rw_n | input | 1 | High requests a read, low requests a write |
| ldac_n | input | 1 | Active-low load line: transparent write or group load |
| addr | input | 2 | Channel select |
| din | input | 12 | Write data from the bus |
| dout | output | 12 | Readback data to the bus |
| dout_oe | output | 1 | High while the block drives the bus |
| dac_out | output | 48 | The four output registers, channel A in the lowest 12 bits |

## Verification
The bench writes distinct codes into the four staging registers with the load line high. It reads them back, then issues a group load. This separates the staging level from the output level and catches swapped channel addresses. Transparent writes of 0xFFF and 0x000 check that only the addressed output moves. Writes and reads with chip select high, and reads with the load line low, must leave every register and the output enable untouched. A clear asserted between clock edges while writes are still being issued must force the clear code at once and hold it. A long run of random bus cycles then compares every output, every clock, with a behavioural model of the two register levels.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_STAGE,
        OP_STAGE_OUT,
        OP_PUSH_ALL,
        OP_READ
    } bus_op_e;
endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
#(
    parameter int NCH = 4,
    localparam int AW = $clog2(NCH)
) (
    input  logic           cs_n,
    input  logic           rw_n,
    input  logic           ldac_n,
    input  logic [AW-1:0]  addr,
    output bus_op_e        op,
    output logic [NCH-1:0] sel
);
    always_comb begin
        op  = OP_NONE;
        sel = '0;
        if (cs_n) begin
            if (!ldac_n) op = OP_PUSH_ALL;
        end else begin
            sel[addr] = 1'b1;
            if (!rw_n) op = ldac_n ? OP_STAGE : OP_STAGE_OUT;
            else if (ldac_n) op = OP_READ;
        end
    end
endmodule

// File: rtl/dacreg_chan.sv
module dacreg_chan
    import dacreg_pkg::*;
#(
    parameter int DW = 12,
    parameter logic [DW-1:0] CLR_CODE = '0
) (
    input  logic          clk,
    input  logic          arst_n,
    input  bus_op_e       op,
    input  logic          hit,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] stage_q,
    output logic [DW-1:0] out_q
);
    typedef struct packed {
        logic [DW-1:0] stage;
        logic [DW-1:0] outv;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_STAGE:     if (hit) st_d.stage = din;
            OP_STAGE_OUT: if (hit) begin
                              st_d.stage = din;
                              st_d.outv  = din;
                          end
            OP_PUSH_ALL:  st_d.outv = st_q.stage;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.stage <= CLR_CODE;
            st_q.outv  <= CLR_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_q = st_q.stage;
    assign out_q   = st_q.outv;
endmodule

// File: rtl/dacreg_rdmux.sv
module dacreg_rdmux #(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int AW = $clog2(NCH)
) (
    input  logic [NCH*DW-1:0] stage_flat,
    input  logic [AW-1:0]     addr,
    input  logic              rd_en,
    output logic [DW-1:0]     dout,
    output logic              dout_oe
);
    always_comb begin
        dout    = rd_en ? stage_flat[addr*DW +: DW] : '0;
        dout_oe = rd_en;
    end
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
    import dacreg_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DW      = 12,
    parameter bit CLR_MID = 1'b1,
    localparam int AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              cs_n,
    input  logic              rw_n,
    input  logic              ldac_n,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_oe,
    output logic [NCH*DW-1:0] dac_out
);
    localparam logic [DW-1:0] CLR_CODE = CLR_MID ? {1'b1, {(DW-1){1'b0}}} : '0;

    bus_op_e           op;
    logic [NCH-1:0]    sel;
    logic [NCH*DW-1:0] stage_flat;
    logic              arst_n;

    assign arst_n = rst_n & clr_n;

    dacreg_decode #(.NCH(NCH)) u_dec (
        .cs_n(cs_n), .rw_n(rw_n), .ldac_n(ldac_n), .addr(addr),
        .op(op), .sel(sel)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        dacreg_chan #(.DW(DW), .CLR_CODE(CLR_CODE)) u_chan (
            .clk(clk), .arst_n(arst_n), .op(op), .hit(sel[k]), .din(din),
            .stage_q(stage_flat[k*DW +: DW]),
            .out_q(dac_out[k*DW +: DW])
        );
    end

    dacreg_rdmux #(.NCH(NCH), .DW(DW)) u_rd (
        .stage_flat(stage_flat), .addr(addr), .rd_en(op == OP_READ),
        .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk #(
    parameter int NCH     = 4,
    parameter int DW      = 12,
    parameter bit CLR_MID = 1'b1,
    localparam int AW = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              cs_n,
    input logic              rw_n,
    input logic              ldac_n,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     din,
    input logic [DW-1:0]     dout,
    input logic              dout_oe,
    input logic [NCH*DW-1:0] dac_out
);
    localparam logic [DW-1:0] CLR_CODE = CLR_MID ? {1'b1, {(DW-1){1'b0}}} : '0;
    localparam logic [NCH*DW-1:0] CLR_ALL = {NCH{CLR_CODE}};

    // R2
    deselect_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);

    // R8
    read_with_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rw_n && !ldac_n) |-> !dout_oe);

    // R3
    stage_only_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!cs_n && !rw_n && ldac_n && clr_n) |=> $stable(dac_out));

    // R6
    idle_holds_out_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cs_n && ldac_n && clr_n) |=> $stable(dac_out));

    // R4
    transparent_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!cs_n && !rw_n && !ldac_n && clr_n) |=> dac_out[$past(addr)*DW +: DW] == $past(din));

    // R10
    clear_forces_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> dac_out == CLR_ALL);

    // R9
    quiet_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0);
endmodule

bind quad_dac_regbank dacreg_chk #(.NCH(NCH), .DW(DW), .CLR_MID(CLR_MID)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .rw_n(rw_n),
    .ldac_n(ldac_n), .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .dac_out(dac_out)
);

// File: tb/quad_dac_regbank_tb.sv
module quad_dac_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, clr_n = 1'b1;
    logic        cs_n = 1'b1, rw_n = 1'b1, ldac_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [11:0] din = '0;
    logic [11:0] dout, dout_z;
    logic        dout_oe, dout_oe_z;
    logic [47:0] dac_out, dac_out_z;

    int    n_cmp = 0, n_bad = 0;
    string tag = "R12";
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;

    logic [11:0] stg_m [4];
    logic [11:0] out_m [4];

    always #10 clk = ~clk;

    quad_dac_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .rw_n(rw_n),
        .ldac_n(ldac_n), .addr(addr), .din(din), .dout(dout),
        .dout_oe(dout_oe), .dac_out(dac_out)
    );

    quad_dac_regbank #(.CLR_MID(1'b0)) u_dut_zero (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .rw_n(rw_n),
        .ldac_n(ldac_n), .addr(addr), .din(din), .dout(dout_z),
        .dout_oe(dout_oe_z), .dac_out(dac_out_z)
    );

    // behavioural model of both register levels
    always @(posedge clk or negedge clr_n or negedge rst_n) begin
        if (!rst_n || !clr_n) begin
            for (int i = 0; i < 4; i++) begin
                stg_m[i] = 12'h800;
                out_m[i] = 12'h800;
            end
        end else if (cs_n) begin
            if (!ldac_n)
                for (int i = 0; i < 4; i++) out_m[i] = stg_m[i];
        end else if (!rw_n) begin
            stg_m[addr] = din;
            if (!ldac_n) out_m[addr] = din;
        end
    end

    task automatic check(string what, logic [11:0] act, logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            logic        exp_oe;
            logic [11:0] exp_do;
            exp_oe = !cs_n && rw_n && ldac_n;
            exp_do = exp_oe ? stg_m[addr] : 12'h000;
            for (int i = 0; i < 4; i++)
                check($sformatf("out ch%0d", i), dac_out[i*12 +: 12], out_m[i]);
            check("oe", {11'b0, dout_oe}, {11'b0, exp_oe});
            check("dout", dout, exp_do);
        end
    end

    task automatic bus(input logic c, input logic r, input logic l,
                       input logic [1:0] a, input logic [11:0] d);
        @(posedge clk);
        #5;
        cs_n = c; rw_n = r; ldac_n = l; addr = a; din = d;
    endtask

    task automatic idle();
        bus(1'b1, 1'b1, 1'b1, 2'd0, 12'h000);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(); idle();
        @(negedge clk);
        tag = "R11";
        for (int i = 0; i < 4; i++) check("zero variant", dac_out_z[i*12 +: 12], 12'h000);
        check("mid variant", dac_out[11:0], 12'h800);

        // R3 stage writes with load high
        tag = "R3";
        for (int i = 0; i < 4; i++) bus(1'b0, 1'b0, 1'b1, 2'(i), 12'h111 * 12'(i + 1) + 12'h005);
        idle();

        // R7 / R1 readback of staging registers by address
        tag = "R7";
        for (int i = 0; i < 4; i++) bus(1'b0, 1'b1, 1'b1, 2'(i), 12'h000);
        tag = "R1";
        for (int i = 3; i >= 0; i--) bus(1'b0, 1'b1, 1'b1, 2'(i), 12'h000);

        // R5 group load
        tag = "R5";
        bus(1'b1, 1'b1, 1'b0, 2'd2, 12'hFFF);
        idle();

        // R6 deselected with load high: hold
        tag = "R6";
        for (int i = 0; i < 4; i++) bus(1'b1, 1'(i & 1), 1'b1, 2'(i), 12'hABC);

        // R2 writes while deselected are ignored; read back to confirm
        tag = "R2";
        for (int i = 0; i < 4; i++) bus(1'b1, 1'b0, 1'b1, 2'(i), 12'h3C3);
        for (int i = 0; i < 4; i++) bus(1'b0, 1'b1, 1'b1, 2'(i), 12'h000);

        // R4 transparent writes, R13 extremes
        tag = "R4";
        bus(1'b0, 1'b0, 1'b0, 2'd1, 12'hFFF);
        bus(1'b0, 1'b0, 1'b0, 2'd3, 12'h000);
        idle();
        tag = "R13";
        bus(1'b0, 1'b0, 1'b1, 2'd0, 12'hFFF);
        bus(1'b0, 1'b1, 1'b1, 2'd0, 12'h000);
        bus(1'b0, 1'b0, 1'b1, 2'd2, 12'h000);
        bus(1'b0, 1'b1, 1'b1, 2'd2, 12'h000);
        bus(1'b0, 1'b1, 1'b1, 2'd1, 12'h000);

        // R8 read with load low: no drive, no change
        tag = "R8";
        for (int i = 0; i < 4; i++) bus(1'b0, 1'b1, 1'b0, 2'(i), 12'h777);
        tag = "R9";
        bus(1'b1, 1'b1, 1'b1, 2'd0, 12'h000);
        bus(1'b0, 1'b0, 1'b1, 2'd2, 12'h456);

        // R10 asynchronous clear mid-cycle while writes continue
        tag = "R10";
        bus(1'b1, 1'b1, 1'b0, 2'd0, 12'h000);
        @(posedge clk);
        #5;
        cs_n = 1'b0; rw_n = 1'b0; ldac_n = 1'b0; addr = 2'd1; din = 12'h9A9;
        clr_n = 1'b0;
        #2;
        check("async out ch1", dac_out[23:12], 12'h800);
        check("async out ch0", dac_out[11:0], 12'h800);
        repeat (3) @(posedge clk);
        #5 clr_n = 1'b1;
        cs_n = 1'b1; ldac_n = 1'b1; rw_n = 1'b1;
        @(negedge clk);
        tag = "R11";
        for (int i = 0; i < 4; i++) check("zero variant after clear", dac_out_z[i*12 +: 12], 12'h000);
        tag = "R10";
        for (int i = 0; i < 4; i++) bus(1'b0, 1'b1, 1'b1, 2'(i), 12'h000);

        // mixed random bus traffic, every rule at once
        tag = "R1";
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom;
            bus(r[0], r[1], r[2] & r[3], 2'(r[5:4]), 12'(r[19:8]));
        end
        idle();
        @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule